// File: doc/BRIEF.md
# Serial Shift-Loaded Control Register File

This block sits on a processor write bus and builds four 5-bit control registers from a stream of single-bit writes. Each accepted write to the upper half of the address space contributes data bit 0 to a hidden 5-bit accumulator. The fifth accepted bit completes a value, and that value is stored in the register that address bits 14:13 select. A write with data bit 7 set is a command rather than a data bit. It restarts the accumulation and forces two mode bits of register 0 high.

Writes that arrive too soon after the previous write are discarded. This is judged from a processor cycle count supplied with the bus, which drops the repeated write that some processors issue during read-modify-write instructions. Each register update produces a one-cycle pulse carrying the register index, so mapping logic downstream can latch the new value.

Top module: `shift_cfg_regs`

## Requirements
- R1: On an accepted write with data bit 7 clear, data bit 0 enters accumulator bit 4 and the previous accumulator contents shift right by one. The first accepted bit of a group therefore ends up in bit 0 of the stored value.
- R2: The fifth accepted data bit of a group stores the completed 5-bit value into register wr_addr[14:13] (0 to 3) at the same clock edge, and the accumulator and bit count clear.
- R3: An accepted write with data bit 7 set discards its data bit and clears the accumulator and count, so the next accepted bit is a first bit. It sets bits 3 and 2 of register 0 and changes no other bit of any register.
- R4: A decoded write is accepted only if no decoded write has occurred since reset, or if its cycle count differs from the previous decoded write's count by at least 2 in both directions modulo 2^CYC_W (cur != last, cur != last+1, last != cur+1). Every decoded write updates the stored last cycle, including rejected ones.
- R5: A write with wr_addr[15] clear has no effect: registers, accumulator and stored last cycle are all unchanged.
- R6: commit_pulse is high for exactly the one cycle after the clock edge that updates a register, and commit_idx gives that register's index. A command write pulses with index 0.
- R7: After reset, register 0 holds 0x0C, registers 1 and 2 hold 0x00, register 3 holds 0x10, and commit_pulse is low.
- R8: A register changes only through R2 or R3. Any other write leaves all four registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data: bit 7 is the command bit, bit 0 is the serial bit |
| cyc_cnt | input | CYC_W (16) | Processor cycle count at this write |
| cfg0 | output | 5 | Register 0 |
| cfg1 | output | 5 | Register 1 |
| cfg2 | output | 5 | Register 2 |
| cfg3 | output | 5 | Register 3 |
| commit_pulse | output | 1 | One-cycle update pulse |
| commit_idx | output | 2 | Index of the register just updated |

## Verification
The spacing filter and the command decode both act on a single write. The case that matters is a command write that arrives one cycle, or zero cycles, after the previous write. Such a write must be rejected as a whole: register 0 must not change and the partial group must survive. The next well-spaced bit then has to continue that group. The bench provokes this case with directed sequences and with random cycle gaps of 0 to 4 mixed with random command bits, and a bench model judges every write against R1 to R8.

// File: rtl/shift_cfg_pkg.sv
package shift_cfg_pkg;
  localparam int ACC_W  = 5;
  localparam int NREG   = 4;
  localparam int IDX_W  = $clog2(NREG);
  localparam int CNT_W  = $clog2(ACC_W + 1);
  localparam logic [ACC_W-1:0] CMD_OR_MASK = 5'h0C;

  function automatic logic [ACC_W-1:0] power_value(input int idx);
    case (idx)
      0:       return 5'h0C;
      3:       return 5'h10;
      default: return 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/shift_cfg_rst_sync.sv
module shift_cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/shift_cfg_filter.sv
module shift_cfg_filter #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr_hi,
  input  logic [CYC_W-1:0] cyc_cnt,
  output logic             accept
);
  logic [CYC_W-1:0] last_q, last_d;
  logic             seen_q, seen_d;
  logic             decoded, far_enough;

  assign decoded    = wr_en && addr_hi;
  assign far_enough = (cyc_cnt != last_q) &&
                      (cyc_cnt != last_q + 1'b1) &&
                      (last_q != cyc_cnt + 1'b1);

  always_comb begin
    last_d = last_q;
    seen_d = seen_q;
    accept = 1'b0;
    if (decoded) begin
      accept = !seen_q || far_enough;
      last_d = cyc_cnt;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      seen_q <= 1'b0;
    end else if (decoded) begin
      last_q <= last_d;
      seen_q <= seen_d;
    end
  end

  p_accept_decoded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (wr_en && addr_hi));
  p_no_same_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && seen_q) |-> (cyc_cnt != last_q));
  p_last_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_hi) |=> (last_q == $past(cyc_cnt)));
endmodule

// File: rtl/shift_cfg_accum.sv
module shift_cfg_accum
  import shift_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             bit_in,
  input  logic             cmd_bit,
  output logic             commit,
  output logic [ACC_W-1:0] commit_val,
  output logic             cmd
);
  logic [ACC_W-1:0] acc_q, acc_d, shifted;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign shifted    = {bit_in, acc_q[ACC_W-1:1]};
  assign commit_val = shifted;

  always_comb begin
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    commit = 1'b0;
    cmd    = 1'b0;
    if (accept) begin
      if (cmd_bit) begin
        cmd   = 1'b1;
        acc_d = '0;
        cnt_d = '0;
      end else if (cnt_q == CNT_W'(ACC_W - 1)) begin
        commit = 1'b1;
        acc_d  = '0;
        cnt_d  = '0;
      end else begin
        acc_d = shifted;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(ACC_W));
  p_clear_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || cmd) |=> (cnt_q == '0 && acc_q == '0));
  p_one_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && cmd));
endmodule

// File: rtl/shift_cfg_bank.sv
module shift_cfg_bank
  import shift_cfg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  logic [IDX_W-1:0]           sel,
  input  logic [ACC_W-1:0]           commit_val,
  input  logic                       cmd,
  output logic [NREG-1:0][ACC_W-1:0] regs,
  output logic                       pulse,
  output logic [IDX_W-1:0]           pulse_idx
);
  logic [IDX_W-1:0] idx_d;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [ACC_W-1:0] nxt;
    logic             en;
    always_comb begin
      nxt = regs[i];
      en  = 1'b0;
      if (commit && sel == IDX_W'(i)) begin
        nxt = commit_val;
        en  = 1'b1;
      end else if (cmd && i == 0) begin
        nxt = regs[i] | CMD_OR_MASK;
        en  = 1'b1;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[i] <= power_value(i);
      else if (en) regs[i] <= nxt;
    end
  end

  assign idx_d = cmd ? '0 : sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse     <= 1'b0;
      pulse_idx <= '0;
    end else begin
      pulse <= commit || cmd;
      if (commit || cmd) pulse_idx <= idx_d;
    end
  end

  p_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit || cmd) |=> $stable(regs));
  p_cmd_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |=> (regs[0][3:2] == 2'b11 && regs[0][4] == $past(regs[0][4])
             && regs[0][1:0] == $past(regs[0][1:0])));
  p_pulse_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || cmd) |=> pulse);
endmodule

// File: rtl/shift_cfg_regs.sv
module shift_cfg_regs
  import shift_cfg_pkg::*;
#(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [CYC_W-1:0] cyc_cnt,
  output logic [ACC_W-1:0] cfg0,
  output logic [ACC_W-1:0] cfg1,
  output logic [ACC_W-1:0] cfg2,
  output logic [ACC_W-1:0] cfg3,
  output logic             commit_pulse,
  output logic [IDX_W-1:0] commit_idx
);
  logic                       rst_n_sync, accept, commit, cmd;
  logic [ACC_W-1:0]           commit_val;
  logic [NREG-1:0][ACC_W-1:0] regs;
  logic                       unused_bits;

  assign unused_bits = ^{wr_addr[12:0], wr_data[6:1]};

  shift_cfg_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  shift_cfg_filter #(.CYC_W(CYC_W)) u_filter (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(wr_en), .addr_hi(wr_addr[15]),
    .cyc_cnt(cyc_cnt), .accept(accept));

  shift_cfg_accum u_accum (
    .clk(clk), .rst_n(rst_n_sync), .accept(accept), .bit_in(wr_data[0]),
    .cmd_bit(wr_data[7]), .commit(commit), .commit_val(commit_val), .cmd(cmd));

  shift_cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n_sync), .commit(commit), .sel(wr_addr[14:13]),
    .commit_val(commit_val), .cmd(cmd), .regs(regs), .pulse(commit_pulse),
    .pulse_idx(commit_idx));

  assign cfg0 = regs[0];
  assign cfg1 = regs[1];
  assign cfg2 = regs[2];
  assign cfg3 = regs[3];
endmodule

// File: tb/shift_cfg_regs_tb_top.sv
module shift_cfg_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cyc_cnt = '0;
  logic [4:0]  cfg0, cfg1, cfg2, cfg3;
  logic        commit_pulse;
  logic [1:0]  commit_idx;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [4:0]  m_reg [4];
  logic [4:0]  m_acc;
  int          m_cnt;
  logic        m_seen;
  logic [15:0] m_last;
  logic        e_pulse;
  logic [1:0]  e_idx;

  shift_cfg_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cyc_cnt(cyc_cnt), .cfg0(cfg0), .cfg1(cfg1),
    .cfg2(cfg2), .cfg3(cfg3), .commit_pulse(commit_pulse),
    .commit_idx(commit_idx));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic far_ok(input logic [15:0] cur, input logic [15:0] last);
    return (cur != last) && (cur != last + 16'd1) && (last != cur + 16'd1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, {cfg0, cfg1, cfg2, cfg3}, {m_reg[0], m_reg[1], m_reg[2], m_reg[3]});
    check({tag, "/R6"}, {commit_pulse, (e_pulse ? commit_idx : 2'b00)}, {e_pulse, e_idx});
  endtask

  task automatic model_reset();
    m_reg[0] = 5'h0C; m_reg[1] = 5'h00; m_reg[2] = 5'h00; m_reg[3] = 5'h10;
    m_acc = '0; m_cnt = 0; m_seen = 1'b0; m_last = '0;
    e_pulse = 1'b0; e_idx = '0;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d, input logic [15:0] c);
    e_pulse = 1'b0; e_idx = '0;
    if (a[15]) begin
      if (!m_seen || far_ok(c, m_last)) begin
        if (d[7]) begin
          m_acc = '0; m_cnt = 0; m_reg[0] = m_reg[0] | 5'h0C;
          e_pulse = 1'b1; e_idx = 2'd0;
        end else begin
          m_acc = {d[0], m_acc[4:1]};
          m_cnt = m_cnt + 1;
          if (m_cnt == 5) begin
            m_reg[a[14:13]] = m_acc;
            m_acc = '0; m_cnt = 0;
            e_pulse = 1'b1; e_idx = a[14:13];
          end
        end
      end
      m_seen = 1'b1; m_last = c;
    end
  endtask

  task automatic do_write(input string tag, input logic [15:0] a, input logic [7:0] d,
                          input logic [15:0] c);
    model_write(a, d, c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; cyc_cnt = c;
    @(negedge clk);
    wr_en = 1'b0;
    check_all(tag);
  endtask

  task automatic idle_check(input string tag);
    e_pulse = 1'b0; e_idx = '0;
    @(negedge clk);
    check_all(tag);
  endtask

  logic [15:0] cyc;
  logic [31:0] seed_dummy;

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R7 reset values");

    cyc = 16'd100;
    // R1 R2: bits 1,0,1,1,0 to register 1 give 0x0D
    do_write("R1 bit", 16'hA000, 8'h01, cyc); cyc += 3;
    do_write("R1 bit", 16'hA000, 8'h00, cyc); cyc += 3;
    do_write("R1 bit", 16'hA000, 8'h01, cyc); cyc += 3;
    do_write("R1 bit", 16'hA000, 8'h01, cyc); cyc += 3;
    do_write("R2 commit", 16'hA000, 8'h00, cyc); cyc += 3;
    check("R1 shift order", {27'd0, cfg1}, 32'h0D);
    idle_check("R6 pulse one cycle");

    // R2: address selects register 3 from the final write
    for (int i = 0; i < 4; i++) begin
      do_write("R2 bits", 16'h8000, 8'h01, cyc); cyc += 2;
    end
    do_write("R2 commit idx3", 16'hE000, 8'h00, cyc); cyc += 2;

    // R3: command in mid-group restarts it
    do_write("R2 partial", 16'hC000, 8'h01, cyc); cyc += 2;
    do_write("R2 partial", 16'hC000, 8'h01, cyc); cyc += 2;
    do_write("R3 command", 16'hFFFF, 8'h80, cyc); cyc += 2;
    for (int i = 0; i < 5; i++) begin
      do_write("R3 restart", 16'hC000, 8'h00, cyc); cyc += 2;
    end

    // R4: too-close writes, last cycle updated by rejected ones
    do_write("R4 first", 16'h8000, 8'h01, cyc);
    do_write("R4 same cyc", 16'h8000, 8'h01, cyc); cyc += 1;
    do_write("R4 plus one", 16'h8000, 8'h01, cyc); cyc += 1;
    do_write("R4 chained", 16'h8000, 8'h80, cyc); cyc += 2;
    do_write("R4 ok", 16'h8000, 8'h00, cyc);
    // R4: close command write rejected, group survives
    do_write("R4 close cmd", 16'h8000, 8'h80, cyc + 16'd1);
    cyc = 16'hFFFF;
    do_write("R4 wrap a", 16'h8000, 8'h01, cyc);
    do_write("R4 wrap b", 16'h8000, 8'h01, 16'h0000);
    do_write("R4 back one", 16'h8000, 8'h01, 16'hFFFF);
    // R5: lower-half writes have no effect and keep last cycle
    do_write("R5 low addr", 16'h7FFF, 8'h80, 16'h0001);
    do_write("R5 low addr", 16'h0000, 8'h01, 16'h0005);
    do_write("R5 after", 16'h8000, 8'h00, 16'h0000);

    // random phase (R8 and all above)
    seed_dummy = $urandom(32'd2718);
    cyc = 16'd500;
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = 16'($urandom);
      if ($urandom % 5 != 0) a[15] = 1'b1;
      d = 8'($urandom);
      d[7] = ($urandom % 8 == 0);
      cyc = cyc + 16'($urandom % 5);
      do_write("R8 random", a, d, cyc);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule